// File: doc/BRIEF.md
# Sector Erase Status Generator

This block is a behavioural model of the status side of a flash device while it programs or erases. A host, or a host poller in simulation, sends it command events for sector erase, chip erase, program, erase suspend, erase resume and reset. Each program or erase adds or removes a per-location "holds zeros" flag. This flag stands in for the array contents. While an operation is active, a status read returns a status byte instead of array data. The byte carries an erase-timer bit, an exceeded-limit bit and a toggle bit. When no operation is active, reads pass the external array data through.

A sector-erase command opens an acceptance window of `WINDOW_CYCLES` clocks. During the window, more sector-erase commands add their locations and restart the window. When the window runs out, the erase itself starts and every command except suspend is ignored. A chip erase skips the window.

A program runs for `PROG_CYCLES` clocks. A program that tries to raise a flagged location back to one never completes. An internal pulse counter then reaches `PULSE_LIMIT` and the block locks into a failed state, which only a reset command leaves.

The controller has six states:
- ST_IDLE
- ST_WINDOW (acceptance window)
- ST_ERASE
- ST_HOLD (erase suspended)
- ST_PROG
- ST_FAIL

Its transitions are:
- IDLE→WINDOW on a sector erase, IDLE→ERASE on a chip erase, IDLE→PROG on a program.
- WINDOW→WINDOW on a further sector erase (window restart), WINDOW→ERASE on expiry, WINDOW→IDLE on reset.
- ERASE→IDLE on completion, ERASE→HOLD on suspend, ERASE→FAIL at the pulse limit.
- HOLD→ERASE on resume.
- PROG→IDLE on completion, PROG→FAIL at the pulse limit.
- FAIL→IDLE on reset.

Top module: `erase_status_gen`

## Requirements
- R1: Status byte encoding: bit 6 is the toggle bit, bit 5 is the exceeded-limit bit and bit 3 is the erase-timer bit. All other bits read 0 while an operation is active. During the acceptance window, bit 3 reads 0 and further sector-erase commands are accepted.
- R2: Each sector-erase command accepted in the window restarts it. Bit 3 stays 0 for `WINDOW_CYCLES` clocks after the latest such command.
- R3: On the edge `WINDOW_CYCLES` clocks after the last sector command, bit 3 becomes 1 and the erase runs. Exactly `ERASE_CYCLES` clocks later the block returns to idle, with the flags of all selected locations cleared.
- R4: While an erase runs, all commands other than suspend are ignored. Suspend makes reads return array data. Resume continues the erase to completion.
- R5: A chip erase skips the window. Bit 3 reads 1 from the next clock, and after `ERASE_CYCLES` clocks all location flags are cleared.
- R6: A program completes after `PROG_CYCLES` clocks. Programming a one into an unflagged location, or a zero into any location, succeeds, and writing a zero sets that location's flag.
- R7: A program of a one into a flagged location stalls. Bit 5 reads 0 until `PULSE_LIMIT` clocks after the command and 1 from that edge on.
- R8: In the failed state all commands except reset are ignored and bit 5 stays 1. A reset command returns reads to array data.
- R9: Bit 6 is 0 at the first read of an operation and inverts after each status read (rd_strobe high at a clock edge) while the operation is active.
- R10: When idle, reads return `array_data`. An asserted `rst_n` at any time returns the block to idle and clears all location flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command event present this clock |
| cmd_op | input | 3 | 1 sector erase, 2 chip erase, 3 program, 4 suspend, 5 resume, 6 reset |
| cmd_addr | input | $clog2(NUM_LOC) | Location for sector erase or program |
| cmd_one | input | 1 | Program writes a one (1) or a zero (0) |
| rd_strobe | input | 1 | Status read; advances the toggle bit at the edge |
| array_data | input | 8 | Array byte returned when no operation is active |
| rd_data | output | 8 | Read data: status byte or array byte |

## Verification
All results are measured in clock edges from the edge that samples the command. Bit 3 must still be 0 after edge `WINDOW_CYCLES`-1 and 1 after edge `WINDOW_CYCLES`. An erase returns array data after exactly `ERASE_CYCLES` further edges, a good program after `PROG_CYCLES`, and bit 5 rises after edge `PULSE_LIMIT`. The bench drives and samples on the falling clock edge, so every check looks at `rd_data` either one cycle before or in the cycle of each boundary. Commands that should be ignored are followed at once by a read of the status byte, and by a later program whose outcome shows whether the location flags changed.

// File: rtl/esg_pkg.sv
package esg_pkg;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_SECTOR  = 3'd1,
        OP_CHIP    = 3'd2,
        OP_PROG    = 3'd3,
        OP_SUSPEND = 3'd4,
        OP_RESUME  = 3'd5,
        OP_RESET   = 3'd6
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WINDOW,
        ST_ERASE,
        ST_HOLD,
        ST_PROG,
        ST_FAIL
    } state_e;

    localparam int BIT_TOGGLE = 6;
    localparam int BIT_LIMIT  = 5;
    localparam int BIT_TIMER  = 3;

endpackage

// File: rtl/esg_window_timer.sv
module esg_window_timer #(
    parameter int WINDOW_CYCLES = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);
    localparam int TW = $clog2(WINDOW_CYCLES + 1);

    logic [TW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= TW'(WINDOW_CYCLES - 1);
        end else if (run && remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign expired = run && (remain == '0);

endmodule

// File: rtl/esg_pulse_counter.sv
module esg_pulse_counter #(
    parameter int LIMIT = 50,
    parameter int CW    = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          run,
    output logic [CW-1:0] count,
    output logic          at_limit
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clear) begin
            count <= '0;
        end else if (run && !at_limit) begin
            count <= count + 1'b1;
        end
    end

    assign at_limit = (count == CW'(LIMIT - 1));

endmodule

// File: rtl/erase_status_gen.sv
module erase_status_gen
    import esg_pkg::*;
#(
    parameter int NUM_LOC       = 16,
    parameter int WINDOW_CYCLES = 20,
    parameter int ERASE_CYCLES  = 30,
    parameter int PROG_CYCLES   = 4,
    parameter int PULSE_LIMIT   = 50,
    localparam int AW           = $clog2(NUM_LOC)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic          cmd_one,
    input  logic          rd_strobe,
    input  logic [7:0]    array_data,
    output logic [7:0]    rd_data
);
    localparam int PCW = $clog2(PULSE_LIMIT + 1);

    state_e state, nxt;
    op_e    op;

    logic is_sector, is_chip, is_prog, is_suspend, is_resume, is_reset;
    logic win_load, win_run, win_expired;
    logic cnt_clear, cnt_run, at_limit;
    logic [PCW-1:0] pulses;
    logic erase_done, prog_done, limit_hit, active;

    logic [NUM_LOC-1:0] flags;
    logic [NUM_LOC-1:0] marks;
    logic [AW-1:0]      prog_addr;
    logic               prog_one;
    logic               prog_stuck;
    logic               tog;

    assign op         = op_e'(cmd_op);
    assign is_sector  = cmd_valid && op == OP_SECTOR;
    assign is_chip    = cmd_valid && op == OP_CHIP;
    assign is_prog    = cmd_valid && op == OP_PROG;
    assign is_suspend = cmd_valid && op == OP_SUSPEND;
    assign is_resume  = cmd_valid && op == OP_RESUME;
    assign is_reset   = cmd_valid && op == OP_RESET;

    assign win_load  = is_sector && (state == ST_IDLE || state == ST_WINDOW);
    assign win_run   = (state == ST_WINDOW);
    assign cnt_clear = (state == ST_IDLE || state == ST_WINDOW);
    assign cnt_run   = (state == ST_ERASE || state == ST_PROG);

    esg_window_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (win_load),
        .run     (win_run),
        .expired (win_expired)
    );

    esg_pulse_counter #(.LIMIT(PULSE_LIMIT), .CW(PCW)) u_pulses (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (cnt_clear),
        .run      (cnt_run),
        .count    (pulses),
        .at_limit (at_limit)
    );

    assign erase_done = (state == ST_ERASE) && (pulses == PCW'(ERASE_CYCLES - 1));
    assign prog_done  = (state == ST_PROG) && !prog_stuck && (pulses == PCW'(PROG_CYCLES - 1));
    assign limit_hit  = cnt_run && at_limit;
    assign active     = (state != ST_IDLE) && (state != ST_HOLD);

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (is_sector)    nxt = ST_WINDOW;
                else if (is_chip) nxt = ST_ERASE;
                else if (is_prog) nxt = ST_PROG;
            end
            ST_WINDOW: begin
                if (is_reset)                       nxt = ST_IDLE;
                else if (win_expired && !is_sector) nxt = ST_ERASE;
            end
            ST_ERASE: begin
                if (erase_done)      nxt = ST_IDLE;
                else if (is_suspend) nxt = ST_HOLD;
                else if (limit_hit)  nxt = ST_FAIL;
            end
            ST_HOLD: begin
                if (is_resume) nxt = ST_ERASE;
            end
            ST_PROG: begin
                if (prog_done)      nxt = ST_IDLE;
                else if (limit_hit) nxt = ST_FAIL;
            end
            ST_FAIL: begin
                if (is_reset) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // location flags, selections and toggle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags      <= '0;
            marks      <= '0;
            prog_addr  <= '0;
            prog_one   <= 1'b0;
            prog_stuck <= 1'b0;
            tog        <= 1'b0;
        end else begin
            if (win_load) marks[cmd_addr] <= 1'b1;
            if (state == ST_IDLE && is_chip) marks <= '1;
            if (state == ST_WINDOW && is_reset) marks <= '0;
            if (erase_done) begin
                flags <= flags & ~marks;
                marks <= '0;
            end
            if (state == ST_IDLE && is_prog && !is_sector && !is_chip) begin
                prog_addr  <= cmd_addr;
                prog_one   <= cmd_one;
                prog_stuck <= cmd_one && flags[cmd_addr];
            end
            if (prog_done && !prog_one) flags[prog_addr] <= 1'b1;
            if (state == ST_IDLE)            tog <= 1'b0;
            else if (rd_strobe && active)    tog <= ~tog;
        end
    end

    // read data
    always_comb begin
        if (active) begin
            rd_data             = '0;
            rd_data[BIT_TOGGLE] = tog;
            rd_data[BIT_LIMIT]  = (state == ST_FAIL);
            rd_data[BIT_TIMER]  = (state == ST_ERASE);
        end else begin
            rd_data = array_data;
        end
    end

    // ---------------- assertions ----------------
    assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WINDOW && is_sector) |=> (state == ST_WINDOW && !win_expired));

    assert_window_expiry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WINDOW && win_expired && !is_sector && !is_reset)
        |=> (state == ST_ERASE && rd_data[BIT_TIMER]));

    assert_erase_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERASE && cmd_valid && op != OP_SUSPEND && !erase_done && !limit_hit)
        |=> state == ST_ERASE);

    assert_chip_direct_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && is_chip) |=> (state == ST_ERASE && rd_data[BIT_TIMER]));

    assert_stuck_never_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROG && prog_stuck) |=> state != ST_IDLE);

    assert_fail_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FAIL && !is_reset) |=> (state == ST_FAIL && rd_data[BIT_LIMIT]));

    assert_toggle_flip_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (active && rd_strobe)
        |=> (state != $past(state) || rd_data[BIT_TOGGLE] != $past(rd_data[BIT_TOGGLE])));

endmodule

// File: tb/erase_status_gen_test.sv
module erase_status_gen_test;
    import esg_pkg::*;

    localparam int W  = 20;
    localparam int E  = 30;
    localparam int P  = 4;
    localparam int L  = 50;
    localparam logic [7:0] ARR = 8'hA5;

    // {addr[3:0], one, expect_fail}
    localparam int NV = 8;
    localparam logic [5:0] PVEC [0:NV-1] = '{
        {4'd2, 1'b0, 1'b0},
        {4'd2, 1'b1, 1'b1},
        {4'd3, 1'b1, 1'b0},
        {4'd3, 1'b0, 1'b0},
        {4'd3, 1'b0, 1'b0},
        {4'd3, 1'b1, 1'b1},
        {4'd7, 1'b0, 1'b0},
        {4'd2, 1'b1, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [3:0] cmd_addr = 4'd0;
    logic       cmd_one = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [7:0] array_data = ARR;
    logic [7:0] rd_data;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    erase_status_gen #(
        .NUM_LOC(16), .WINDOW_CYCLES(W), .ERASE_CYCLES(E),
        .PROG_CYCLES(P), .PULSE_LIMIT(L)
    ) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_one(cmd_one), .rd_strobe(rd_strobe),
        .array_data(array_data), .rd_data(rd_data)
    );

    task automatic check(input string tag, input logic [7:0] exp);
        tests++;
        if (rd_data !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, rd_data, exp);
        end
    endtask

    task automatic issue(input op_e o, input logic [3:0] a, input logic one);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = o;
        cmd_addr  = a;
        cmd_one   = one;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op    = 3'd0;
    endtask

    // program that must succeed: busy until edge P, then array data
    task automatic good_prog(input string tag, input logic [3:0] a, input logic one);
        issue(OP_PROG, a, one);
        repeat (P - 1) @(negedge clk);
        check(tag, 8'h00);
        @(negedge clk);
        check(tag, ARR);
    endtask

    // program that must stall and fail at edge L, then reset
    task automatic bad_prog(input string tag, input logic [3:0] a);
        issue(OP_PROG, a, 1'b1);
        repeat (L - 1) @(negedge clk);
        check(tag, 8'h00);
        @(negedge clk);
        check(tag, 8'h20);
        issue(OP_RESET, 4'd0, 1'b0);
        check(tag, ARR);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state reads array data
        check("R10 reset idle", ARR);

        // R6/R7 program vector table
        for (int i = 0; i < NV; i++) begin
            if (PVEC[i][0]) bad_prog("R7 vector", PVEC[i][5:2]);
            else            good_prog("R6 vector", PVEC[i][5:2], PVEC[i][1]);
        end
        // flags now set on 2, 3, 7

        // R1/R2/R3 window restart and erase
        issue(OP_SECTOR, 4'd2, 1'b0);
        check("R1 window bit3 low", 8'h00);
        repeat (10) @(negedge clk);
        issue(OP_SECTOR, 4'd7, 1'b0);
        check("R1 second sector accepted", 8'h00);
        repeat (W - 1) @(negedge clk);
        check("R2 window restarted", 8'h00);
        @(negedge clk);
        check("R3 bit3 rises", 8'h08);
        repeat (E - 1) @(negedge clk);
        check("R3 erase still running", 8'h08);
        @(negedge clk);
        check("R3 erase done", ARR);
        good_prog("R3 loc2 cleared", 4'd2, 1'b1);
        good_prog("R3 loc7 cleared", 4'd7, 1'b1);
        bad_prog("R3 loc3 untouched", 4'd3);

        // R4 lockout and suspend/resume
        issue(OP_SECTOR, 4'd3, 1'b0);
        repeat (W) @(negedge clk);
        check("R4 erase start", 8'h08);
        issue(OP_PROG, 4'd9, 1'b0);
        check("R4 program ignored", 8'h08);
        issue(OP_RESET, 4'd0, 1'b0);
        check("R4 reset ignored", 8'h08);
        issue(OP_SUSPEND, 4'd0, 1'b0);
        check("R4 suspended array read", ARR);
        repeat (5) @(negedge clk);
        check("R4 suspend holds", ARR);
        issue(OP_RESUME, 4'd0, 1'b0);
        check("R4 resumed", 8'h08);
        repeat (E) @(negedge clk);
        check("R4 erase completes", ARR);
        good_prog("R4 loc3 erased", 4'd3, 1'b1);
        good_prog("R4 loc9 not programmed", 4'd9, 1'b1);

        // R5 chip erase
        good_prog("R6 set loc5", 4'd5, 1'b0);
        issue(OP_CHIP, 4'd0, 1'b0);
        check("R5 bit3 at once", 8'h08);
        repeat (E - 1) @(negedge clk);
        check("R5 chip erase running", 8'h08);
        @(negedge clk);
        check("R5 chip erase done", ARR);
        good_prog("R5 loc5 cleared", 4'd5, 1'b1);

        // R9 toggle, R7 limit, R8 failed lock
        good_prog("R6 set loc5 again", 4'd5, 1'b0);
        issue(OP_PROG, 4'd5, 1'b1);
        rd_strobe = 1'b1;
        #1 v1 = rd_data;
        tests++;
        if (v1 !== 8'h00) begin
            fails++;
            $display("FAIL R9 first read: got %h expected %h", v1, 8'h00);
        end
        @(negedge clk);
        rd_strobe = 1'b0;
        check("R9 toggled", 8'h40);
        repeat (L - 2) @(negedge clk);
        check("R7 before limit", 8'h40);
        @(negedge clk);
        check("R7 limit reached", 8'h60);
        issue(OP_SECTOR, 4'd1, 1'b0);
        check("R8 sector ignored", 8'h60);
        issue(OP_RESET, 4'd0, 1'b0);
        check("R8 reset command", ARR);

        // R10 asynchronous reset mid-operation clears flags
        issue(OP_PROG, 4'd5, 1'b1);
        check("R10 stalled busy", 8'h00);
        rst_n = 1'b0;
        #1 check("R10 async reset", ARR);
        @(negedge clk);
        rst_n = 1'b1;
        good_prog("R10 flags cleared", 4'd5, 1'b1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule